// File: doc/BRIEF.md
# Configurable Ready/Busy Status Pin Driver

This block drives one status output for an embedded write state machine. After reset it works as a level ready/busy line. The line is low while the state machine is busy, and high when the machine is idle or suspended. A configuration write can move the pin into one of three interrupt-style modes. In those modes the line rests high and drops low for a fixed number of clock cycles when an enabled completion event occurs. Erase completion and program completion can be enabled separately or together.

The configuration comes from a command decoder outside this block, as a one-cycle write strobe and an 8-bit code. The block takes a code only when the state machine is neither busy nor suspended. An unknown code is refused, and the block raises an error flag that the surrounding logic records as status bits 4 and 5. The selected mode holds until the next accepted configuration write or until the reset pin goes low.

Top module: `stspin_top`

## Requirements
- R1: While `rst_pin_n` is low, and after it rises, `sts_pin` is 1, `cfg_bad` is 0 and the mode is level mode.
- R2: In level mode, `sts_pin` after a rising clock edge equals NOT(`sm_busy` AND NOT `sm_susp`), using the inputs sampled at that edge.
- R3: An accepted write of code 8'h00 selects level mode.
- R4: An accepted write of code 8'h01 selects the erase-pulse mode. In this mode `ers_done` starts a low pulse and `pgm_done` has no effect on the pin.
- R5: An accepted write of code 8'h02 selects the program-pulse mode. In this mode `pgm_done` starts a low pulse and `ers_done` has no effect on the pin.
- R6: An accepted write of code 8'h03 selects the mode in which both `ers_done` and `pgm_done` start a pulse.
- R7: Suppose an enabled event is sampled at edge k and no other event follows. Then `sts_pin` is low after edges k through k+PULSE_CYC-1 and high again after edge k+PULSE_CYC.
- R8: An enabled event that arrives during a pulse restarts the pulse. The pin then stays low for PULSE_CYC cycles counted from the edge that sampled the new event.
- R9: In any pulse mode, the pin is high whenever no pulse is running, whatever the value of `sm_busy`.
- R10: An accepted write of a code above 8'h03 leaves the mode unchanged, and `cfg_bad` is 1 for exactly the cycle after that write.
- R11: A write made while `sm_busy` or `sm_susp` is 1 has no effect. The mode does not change and `cfg_bad` stays 0.
- R12: The mode persists across later cycles until another accepted write. Driving `rst_pin_n` low returns the block to level mode.
- R13: An accepted valid write cancels any pulse in progress, unless the same edge also samples an event that the new mode enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_pin_n | input | 1 | Asynchronous active-low reset pin |
| cfg_wr | input | 1 | One-cycle configuration write strobe |
| cfg_code | input | CODE_W | Configuration code |
| sm_busy | input | 1 | State machine busy |
| sm_susp | input | 1 | State machine suspended |
| pgm_done | input | 1 | Program-complete event strobe |
| ers_done | input | 1 | Erase-complete event strobe |
| sts_pin | output | 1 | Status pin level (registered) |
| cfg_bad | output | 1 | Invalid-code flag, one cycle |

## Verification
Every result appears one register stage after the edge that samples its cause. The pin reflects the busy level, the new mode and the pulse start in the cycle right after that edge. The error flag is also high for that single following cycle. A pulse then stays low for exactly PULSE_CYC cycles. The bench drives inputs on the falling edge and updates a reference model at each rising edge. It compares both outputs one time unit after that edge, so every cycle of a pulse, including its first and last, is checked where it is due.

// File: rtl/stspin_pkg.sv
package stspin_pkg;

  typedef enum logic [1:0] {
    SM_LEVEL = 2'b00,
    SM_ERS   = 2'b01,
    SM_PGM   = 2'b10,
    SM_BOTH  = 2'b11
  } sts_mode_e;

  // Pin level used in level mode.
  function automatic logic level_of(input logic busy, input logic susp);
    return !(busy && !susp);
  endfunction

  // The mode's enable bits select which events start a pulse.
  function automatic logic fires(input sts_mode_e m, input logic pgm, input logic ers);
    return (m[0] && ers) || (m[1] && pgm);
  endfunction

endpackage

// File: rtl/stspin_cfg.sv
module stspin_cfg
  import stspin_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              busy_i,
  input  logic              susp_i,
  output sts_mode_e         mode_q,
  output sts_mode_e         mode_nxt,
  output logic              load_w,
  output logic              bad_q
);
  localparam int SEL_W = 2;

  logic idle_w;
  logic valid_w;
  logic bad_w;

  assign idle_w  = !busy_i && !susp_i;
  assign valid_w = (code_i >> SEL_W) == '0;
  assign load_w  = wr_i && idle_w && valid_w;
  assign bad_w   = wr_i && idle_w && !valid_w;

  always_comb begin
    mode_nxt = mode_q;
    if (load_w) mode_nxt = sts_mode_e'(code_i[SEL_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= SM_LEVEL;
      bad_q  <= 1'b0;
    end else begin
      mode_q <= mode_nxt;
      bad_q  <= bad_w;
    end
  end

  // R10: a refused code keeps the previous mode
  a_r10_bad_keeps_mode: assert property (@(posedge clk) disable iff (!rst_n)
    bad_q |-> $stable(mode_q));

  // R11: writes while busy or suspended are dropped
  a_r11_busy_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && (busy_i || susp_i)) |=> ($stable(mode_q) && !bad_q));

endmodule

// File: rtl/stspin_pulse.sv
module stspin_pulse #(
  parameter int PULSE_CYC = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  input  logic clr_i,
  output logic active_nxt
);
  localparam int CW = $clog2(PULSE_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nxt;

  always_comb begin
    if (trig_i)              cnt_nxt = CW'(PULSE_CYC);
    else if (clr_i)          cnt_nxt = '0;
    else if (cnt_q != '0)    cnt_nxt = cnt_q - CW'(1);
    else                     cnt_nxt = cnt_q;
  end

  assign active_nxt = cnt_nxt != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

  // R7: counter never exceeds the pulse length
  a_r7_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(PULSE_CYC));

  // R7: a running pulse counts down one per cycle
  a_r7_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && !trig_i && !clr_i) |=> (cnt_q == $past(cnt_q) - CW'(1)));

  // R8: a new event reloads the full length
  a_r8_retrigger_reload: assert property (@(posedge clk) disable iff (!rst_n)
    trig_i |=> (cnt_q == CW'(PULSE_CYC)));

endmodule

// File: rtl/stspin_drive.sv
module stspin_drive
  import stspin_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  sts_mode_e mode_nxt,
  input  logic      active_nxt,
  input  logic      busy_i,
  input  logic      susp_i,
  output logic      pin_q
);
  logic pin_d;

  always_comb begin
    if (mode_nxt == SM_LEVEL) pin_d = level_of(busy_i, susp_i);
    else                      pin_d = !active_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b1;
    else        pin_q <= pin_d;
  end

endmodule

// File: rtl/stspin_top.sv
module stspin_top
  import stspin_pkg::*;
#(
  parameter int CODE_W    = 8,
  parameter int PULSE_CYC = 13
) (
  input  logic              clk,
  input  logic              rst_pin_n,
  input  logic              cfg_wr,
  input  logic [CODE_W-1:0] cfg_code,
  input  logic              sm_busy,
  input  logic              sm_susp,
  input  logic              pgm_done,
  input  logic              ers_done,
  output logic              sts_pin,
  output logic              cfg_bad
);
  sts_mode_e mode_q;
  sts_mode_e mode_nxt;
  logic      load_w;
  logic      trig_w;
  logic      active_nxt;
  logic      active_q;

  stspin_cfg #(.CODE_W(CODE_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_pin_n),
    .wr_i     (cfg_wr),
    .code_i   (cfg_code),
    .busy_i   (sm_busy),
    .susp_i   (sm_susp),
    .mode_q   (mode_q),
    .mode_nxt (mode_nxt),
    .load_w   (load_w),
    .bad_q    (cfg_bad)
  );

  // Events are judged against the mode in force after this edge.
  assign trig_w = fires(mode_nxt, pgm_done, ers_done);

  stspin_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk        (clk),
    .rst_n      (rst_pin_n),
    .trig_i     (trig_w),
    .clr_i      (load_w),
    .active_nxt (active_nxt)
  );

  stspin_drive u_drive (
    .clk        (clk),
    .rst_n      (rst_pin_n),
    .mode_nxt   (mode_nxt),
    .active_nxt (active_nxt),
    .busy_i     (sm_busy),
    .susp_i     (sm_susp),
    .pin_q      (sts_pin)
  );

  // Registered copy of pulse activity, for the checks below.
  always_ff @(posedge clk or negedge rst_pin_n) begin
    if (!rst_pin_n) active_q <= 1'b0;
    else            active_q <= active_nxt;
  end

  // R9: in a pulse mode the pin rests high when no pulse runs
  a_r9_idle_high: assert property (@(posedge clk) disable iff (!rst_pin_n)
    (mode_q != SM_LEVEL && !active_q) |-> sts_pin);

  // R7: a pulse in a pulse mode holds the pin low
  a_r7_pulse_low: assert property (@(posedge clk) disable iff (!rst_pin_n)
    (mode_q != SM_LEVEL && active_q) |-> !sts_pin);

  // R13: an accepted write with no event stops any pulse
  a_r13_write_clears: assert property (@(posedge clk) disable iff (!rst_pin_n)
    (load_w && !trig_w) |=> !active_q);

endmodule

// File: tb/sim_stspin_top.sv
module sim_stspin_top;
  localparam int CLK_P  = 20;
  localparam int PW     = 13;
  localparam int WD_CYC = 20000;

  logic       clk = 1'b0;
  logic       rst_pin_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_code = 8'h00;
  logic       sm_busy = 1'b0;
  logic       sm_susp = 1'b0;
  logic       pgm_done = 1'b0;
  logic       ers_done = 1'b0;
  logic       sts_pin;
  logic       cfg_bad;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference state
  logic [1:0] m_mode = 2'b00;
  int         m_cnt = 0;
  logic       m_pin = 1'b1;
  logic       m_err = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  stspin_top #(.CODE_W(8), .PULSE_CYC(PW)) u0 (
    .clk(clk), .rst_pin_n(rst_pin_n), .cfg_wr(cfg_wr), .cfg_code(cfg_code),
    .sm_busy(sm_busy), .sm_susp(sm_susp), .pgm_done(pgm_done),
    .ers_done(ers_done), .sts_pin(sts_pin), .cfg_bad(cfg_bad)
  );

  function automatic logic exp_level(input logic b, input logic s);
    if (b && !s) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic exp_fire(input logic [1:0] m, input logic p, input logic e);
    return (m == 2'b01 && e) || (m == 2'b10 && p) || (m == 2'b11 && (p || e));
  endfunction

  task automatic check(input string tag);
    total++;
    if (sts_pin !== m_pin || cfg_bad !== m_err) begin
      bad++;
      $display("FAIL %s: sts_pin=%b cfg_bad=%b expected sts_pin=%b cfg_bad=%b",
               tag, sts_pin, cfg_bad, m_pin, m_err);
    end
  endtask

  task automatic cyc(input string tag, input logic we, input logic [7:0] code,
                     input logic b, input logic s, input logic p, input logic e);
    logic acc;
    logic ok;
    logic trg;
    @(negedge clk);
    cfg_wr = we; cfg_code = code; sm_busy = b; sm_susp = s;
    pgm_done = p; ers_done = e;
    @(posedge clk);
    acc = we && !b && !s;
    ok  = code < 8'd4;
    if (acc && ok) m_mode = code[1:0];
    m_err = acc && !ok;
    trg = exp_fire(m_mode, p, e);
    if (trg)            m_cnt = PW;
    else if (acc && ok) m_cnt = 0;
    else if (m_cnt > 0) m_cnt = m_cnt - 1;
    m_pin = (m_mode == 2'b00) ? exp_level(b, s) : (m_cnt == 0);
    #1;
    check(tag);
  endtask

  task automatic idle(input string tag, input int n, input logic b);
    for (int i = 0; i < n; i++) cyc(tag, 1'b0, 8'h00, b, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_pin_n = 1'b0;
    cfg_wr = 0; pgm_done = 0; ers_done = 0; sm_busy = 1; sm_susp = 0;
    m_mode = 2'b00; m_cnt = 0; m_pin = 1'b1; m_err = 1'b0;
    #1;
    check("R1 in reset");
    @(negedge clk);
    @(negedge clk);
    rst_pin_n = 1'b1;
    #1;
    check("R1 released");
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: run still active, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int sd;
    sd = $urandom(32'd1234);
    do_reset();
    // R2 level mode
    cyc("R2 busy", 0, 8'h00, 1, 0, 0, 0);
    cyc("R2 busy+susp", 0, 8'h00, 1, 1, 0, 0);
    cyc("R2 ready", 0, 8'h00, 0, 0, 1, 1);
    // R4 erase pulse mode
    cyc("R4 write 01", 1, 8'h01, 0, 0, 0, 0);
    cyc("R4 pgm ignored", 0, 8'h00, 0, 0, 1, 0);
    idle("R4 stays high", 2, 0);
    cyc("R7 erase start", 0, 8'h00, 0, 0, 0, 1);
    idle("R7 pulse low/end", PW + 2, 0);
    idle("R9 busy idle high", 3, 1);
    // R11 write while busy / suspended
    cyc("R11 busy write", 1, 8'h03, 1, 0, 0, 0);
    cyc("R11 susp write bad code", 1, 8'h77, 0, 1, 0, 0);
    cyc("R11 pgm still ignored", 0, 8'h00, 0, 0, 1, 0);
    idle("R11 high", 2, 0);
    // R5 program mode
    cyc("R5 write 02", 1, 8'h02, 0, 0, 0, 0);
    cyc("R5 erase ignored", 0, 8'h00, 0, 0, 0, 1);
    cyc("R5 pgm start", 0, 8'h00, 0, 0, 1, 0);
    idle("R5 pulse", PW + 1, 1);
    // R6 both, R8 retrigger
    cyc("R6 write 03", 1, 8'h03, 0, 0, 0, 0);
    cyc("R6 erase start", 0, 8'h00, 0, 0, 0, 1);
    idle("R8 mid", 5, 0);
    cyc("R8 retrigger pgm", 0, 8'h00, 0, 0, 1, 0);
    idle("R8 full length", PW + 1, 0);
    // R10 invalid code
    cyc("R10 write 5A", 1, 8'h5A, 0, 0, 0, 0);
    cyc("R10 flag drops", 0, 8'h00, 0, 0, 0, 0);
    cyc("R10 mode kept", 0, 8'h00, 0, 0, 0, 1);
    idle("R10 pulse", 3, 0);
    // R13 write during pulse
    cyc("R13 write 01 clears", 1, 8'h01, 0, 0, 0, 0);
    idle("R13 high", 3, 0);
    // R3 back to level
    cyc("R3 write 00", 1, 8'h00, 0, 0, 0, 1);
    cyc("R3 level busy", 0, 8'h00, 1, 0, 0, 0);
    // R12 persistence then reset
    cyc("R12 write 02", 1, 8'h02, 0, 0, 0, 0);
    idle("R12 persists", 4, 1);
    do_reset();
    cyc("R12 level after reset", 0, 8'h00, 1, 0, 1, 1);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic we, b, s, p, e;
      logic [7:0] c;
      we = ($urandom % 8) == 0;
      c  = (($urandom % 4) == 0) ? 8'($urandom) : 8'($urandom % 4);
      b  = ($urandom % 3) == 0;
      s  = ($urandom % 6) == 0;
      p  = ($urandom % 10) == 0;
      e  = ($urandom % 10) == 0;
      cyc((m_mode == 2'b00) ? "R2 random" : "R7 random", we, c, b, s, p, e);
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule